// File: doc/BRIEF.md
# Reorder buffer commit unit

This block is the in-order retirement stage of an out-of-order integer core. It is a circular buffer of result slots. A slot is claimed at the tail each time the front end issues an instruction. Slots are filled from two completion broadcasts, one from the ALU and one from the memory pipe. Finished slots are released strictly from the head. For each release the block drives the architectural register write, the index of the released slot and the next program counter the instruction actually produced.

Two cases at retirement need extra handling. The first is a slot whose computed next PC differs from the PC that was predicted at issue. Its release raises a flush pulse, and the buffer then empties itself one cycle later. The second is the exit instruction word. Its release latches a halt code made of a done flag over the low byte of register a0.

The block also does two jobs for the issue side. It gates issue on free space, both its own and that of the downstream queue. For the instruction issued in the previous cycle, it forwards any source operand that an older, finished slot already holds.

Top module: `rob_commit_unit`

## Requirements
- R1: After reset the buffer is empty. `iss_idx` is 0, `iss_ready` is 1 when `q_free` is non-zero, and `cmt_valid`, `flush`, `halt` and `pred_valid` are all 0.
- R2: `iss_ready` is 1 only when all three hold: the buffer is not full, no flush pulse is active, and `q_free` is larger than 1 if an instruction issued in the previous cycle (larger than 0 otherwise).
- R3: An accepted issue takes the slot shown on `iss_idx`. Successive issues get consecutive slot numbers, modulo the depth.
- R4: A completion broadcast is taken only when its 2-bit status equals 2'b10 and the named slot is waiting. Any other status has no effect.
- R5: Slots retire one per cycle in allocation order. A slot that is not finished blocks every younger slot, even finished ones.
- R6: A retirement pulses `cmt_valid` for one cycle with the slot's destination flag, destination index, result value, slot index and next PC. A memory completion yields issue PC + 4 as the next PC. An ALU completion yields the PC it broadcasts.
- R7: When the retiring slot's ALU next PC differs from its predicted next PC, `flush` rises together with `cmt_valid`. During that cycle `iss_ready` is 0. In the next cycle the buffer is empty, so `iss_idx` is 0 and the flushed slots never retire.
- R8: Retiring the word 32'h0FF00513 sets `halt` to {1'b1, a0_low}. Bit 8 is the done flag. The value then holds until reset.
- R9: Issuing an instruction whose opcode (bits 6:0) is 7'b1100111 clears `pred_valid` in the next cycle. Its retirement sets `pred_valid` to 1 and `pred_pc` to its next PC.
- R10: In the cycle after an issue, `opN_hit` is 1 only when three things hold: the source register is non-zero, the youngest older slot writing that register is finished, and that slot still lies between the head and the issued slot. `opN_val` then carries that slot's result. A younger writer that is still pending hides an older finished one.
- R11: With the full depth allocated and nothing retired, `iss_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_instr | input | 32 | Instruction word being issued |
| iss_pc | input | 32 | PC of the issued instruction |
| iss_pred_npc | input | 32 | Predicted next PC of the issued instruction |
| iss_has_dst | input | 1 | Issued instruction writes a register |
| iss_dst | input | 5 | Destination register |
| iss_src1 | input | 5 | First source register |
| iss_src2 | input | 5 | Second source register |
| q_free | input | log2(DEPTH)+1 | Free entries reported by the target issue queue |
| iss_ready | output | 1 | Issue may be accepted this cycle |
| iss_idx | output | log2(DEPTH) | Slot an accepted issue receives |
| alu_stat | input | 2 | ALU broadcast status, 2'b10 = valid |
| alu_idx | input | log2(DEPTH) | Slot named by the ALU broadcast |
| alu_val | input | 32 | ALU result |
| alu_npc | input | 32 | Next PC computed by the ALU |
| mem_stat | input | 2 | Memory broadcast status, 2'b10 = valid |
| mem_idx | input | log2(DEPTH) | Slot named by the memory broadcast |
| mem_val | input | 32 | Memory result |
| a0_low | input | 8 | Low byte of register a0 |
| cmt_valid | output | 1 | Retirement strobe |
| cmt_has_dst | output | 1 | Retiring slot writes a register |
| cmt_dst | output | 5 | Retiring destination register |
| cmt_val | output | 32 | Retiring result value |
| cmt_idx | output | log2(DEPTH) | Retiring slot index |
| cmt_npc | output | 32 | Actual next PC of the retiring instruction |
| flush | output | 1 | Pipeline flush request |
| halt | output | 9 | Done flag (bit 8) and exit code |
| pred_valid | output | 1 | Predicted PC is usable |
| pred_pc | output | 32 | Predicted PC from the last retired indirect jump |
| op1_hit | output | 1 | First source forwarded |
| op1_val | output | 32 | First source value |
| op2_hit | output | 1 | Second source forwarded |
| op2_val | output | 32 | Second source value |

## Verification
The assertions take the issue and completion sides to be well behaved. `iss_valid` is only relied on when `iss_ready` is high, a completion only names a slot that is allocated and waiting, and the two broadcasts never name the same slot in one cycle. The stimulus keeps to these rules. It issues only after reading `iss_ready`, it completes each slot exactly once using indices returned at issue, and it sends ALU and memory completions in separate cycles. The single deliberate exception is one completion aimed at a slot that a flush has discarded.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int XLEN = 32;
    localparam int RAW  = 5;

    localparam logic [31:0] HALT_WORD = 32'h0FF0_0513;
    localparam logic [6:0]  OPC_JALR  = 7'b110_0111;
    localparam logic [1:0]  BCAST_OK  = 2'b10;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd3
    } slot_st_e;

    typedef struct packed {
        slot_st_e          st;
        logic [31:0]       instr;
        logic [XLEN-1:0]   pred_npc;
        logic [XLEN-1:0]   res_npc;
        logic              has_dst;
        logic [RAW-1:0]    dst;
        logic [XLEN-1:0]   val;
        logic              mis;
        logic              npc_rdy;
    } slot_t;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic                       clear,
    output logic [$clog2(DEPTH)-1:0]   head,
    output logic [$clog2(DEPTH)-1:0]   tail,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int IW = $clog2(DEPTH);

    typedef struct packed {
        logic [IW-1:0] head;
        logic [IW-1:0] tail;
        logic [IW:0]   cnt;
    } ptr_t;

    ptr_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (clear) begin
            p_d = '0;
        end else begin
            if (push) p_d.tail = p_q.tail + 1'b1;
            if (pop)  p_d.head = p_q.head + 1'b1;
            p_d.cnt = p_q.cnt + (IW+1)'(push) - (IW+1)'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign head  = p_q.head;
    assign tail  = p_q.tail;
    assign count = p_q.cnt;
endmodule

// File: rtl/rob_src_lookup.sv
module rob_src_lookup
    import rob_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                       en,
    input  logic [RAW-1:0]             src,
    input  logic [$clog2(DEPTH)-1:0]   head,
    input  logic [$clog2(DEPTH)-1:0]   newest,
    input  logic [DEPTH-1:0]           wr_en,
    input  logic [DEPTH-1:0]           done,
    input  logic [RAW-1:0]             wr_reg [DEPTH],
    input  logic [XLEN-1:0]            wr_val [DEPTH],
    output logic                       hit,
    output logic [XLEN-1:0]            val
);
    localparam int IW = $clog2(DEPTH);

    logic [IW-1:0] span_d;

    // Walk from oldest to youngest; the last matching writer wins.
    always_comb begin
        span_d = newest - head;
        hit    = 1'b0;
        val    = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if ((IW'(k) < span_d) && wr_en[head + IW'(k)] &&
                (wr_reg[head + IW'(k)] == src)) begin
                hit = done[head + IW'(k)];
                val = done[head + IW'(k)] ? wr_val[head + IW'(k)] : '0;
            end
        end
        if (!en || (src == '0)) begin
            hit = 1'b0;
            val = '0;
        end
    end
endmodule

// File: rtl/rob_commit_unit.sv
module rob_commit_unit
    import rob_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       iss_valid,
    input  logic [31:0]                iss_instr,
    input  logic [XLEN-1:0]            iss_pc,
    input  logic [XLEN-1:0]            iss_pred_npc,
    input  logic                       iss_has_dst,
    input  logic [RAW-1:0]             iss_dst,
    input  logic [RAW-1:0]             iss_src1,
    input  logic [RAW-1:0]             iss_src2,
    input  logic [$clog2(DEPTH):0]     q_free,
    output logic                       iss_ready,
    output logic [$clog2(DEPTH)-1:0]   iss_idx,
    input  logic [1:0]                 alu_stat,
    input  logic [$clog2(DEPTH)-1:0]   alu_idx,
    input  logic [XLEN-1:0]            alu_val,
    input  logic [XLEN-1:0]            alu_npc,
    input  logic [1:0]                 mem_stat,
    input  logic [$clog2(DEPTH)-1:0]   mem_idx,
    input  logic [XLEN-1:0]            mem_val,
    input  logic [7:0]                 a0_low,
    output logic                       cmt_valid,
    output logic                       cmt_has_dst,
    output logic [RAW-1:0]             cmt_dst,
    output logic [XLEN-1:0]            cmt_val,
    output logic [$clog2(DEPTH)-1:0]   cmt_idx,
    output logic [XLEN-1:0]            cmt_npc,
    output logic                       flush,
    output logic [8:0]                 halt,
    output logic                       pred_valid,
    output logic [XLEN-1:0]            pred_pc,
    output logic                       op1_hit,
    output logic [XLEN-1:0]            op1_val,
    output logic                       op2_hit,
    output logic [XLEN-1:0]            op2_val
);
    localparam int IW   = $clog2(DEPTH);
    localparam int NSRC = 2;

    typedef struct packed {
        logic                     cmt_valid;
        logic                     cmt_has_dst;
        logic [RAW-1:0]           cmt_dst;
        logic [XLEN-1:0]          cmt_val;
        logic [IW-1:0]            cmt_idx;
        logic [XLEN-1:0]          cmt_npc;
        logic                     flush;
        logic [8:0]               halt;
        logic                     pred_valid;
        logic [XLEN-1:0]          pred_pc;
        logic                     issued_last;
        logic [IW-1:0]            last_idx;
        logic [NSRC-1:0][RAW-1:0] last_src;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    slot_t ent_d [DEPTH];
    slot_t ent_q [DEPTH];

    logic          push, pop;
    logic [IW-1:0] head, tail;
    logic [IW:0]   count;

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .clear (ctl_q.flush),
        .head  (head),
        .tail  (tail),
        .count (count)
    );

    // Flattened per-slot views for the operand search.
    logic [DEPTH-1:0] wr_en, done;
    logic [RAW-1:0]   wr_reg [DEPTH];
    logic [XLEN-1:0]  wr_val [DEPTH];

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            wr_en[k]  = ent_q[k].has_dst && (ent_q[k].st != ST_FREE);
            done[k]   = (ent_q[k].st == ST_DONE);
            wr_reg[k] = ent_q[k].dst;
            wr_val[k] = ent_q[k].val;
        end
    end

    logic            op_hit [NSRC];
    logic [XLEN-1:0] op_val [NSRC];

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            rob_src_lookup #(.DEPTH(DEPTH)) u_lookup (
                .en     (ctl_q.issued_last),
                .src    (ctl_q.last_src[g]),
                .head   (head),
                .newest (ctl_q.last_idx),
                .wr_en  (wr_en),
                .done   (done),
                .wr_reg (wr_reg),
                .wr_val (wr_val),
                .hit    (op_hit[g]),
                .val    (op_val[g])
            );
        end
    endgenerate

    always_comb begin
        ctl_d             = ctl_q;
        ent_d             = ent_q;
        ctl_d.cmt_valid   = 1'b0;
        ctl_d.flush       = 1'b0;
        ctl_d.issued_last = 1'b0;
        push              = 1'b0;
        pop               = 1'b0;

        iss_ready = !ctl_q.flush && (count < (IW+1)'(DEPTH)) &&
                    (q_free > (IW+1)'(ctl_q.issued_last));

        if (ctl_q.flush) begin
            for (int k = 0; k < DEPTH; k++) ent_d[k].st = ST_FREE;
        end else begin
            // ALU completion
            if ((alu_stat == BCAST_OK) && (ent_q[alu_idx].st == ST_WAIT)) begin
                ent_d[alu_idx].st      = ST_DONE;
                ent_d[alu_idx].val     = alu_val;
                ent_d[alu_idx].res_npc = alu_npc;
                ent_d[alu_idx].npc_rdy = 1'b1;
                ent_d[alu_idx].mis     = (alu_npc != ent_q[alu_idx].pred_npc);
            end
            // Memory completion: next PC was fixed at issue
            if ((mem_stat == BCAST_OK) && (ent_q[mem_idx].st == ST_WAIT)) begin
                ent_d[mem_idx].st      = ST_DONE;
                ent_d[mem_idx].val     = mem_val;
                ent_d[mem_idx].npc_rdy = 1'b1;
                ent_d[mem_idx].mis     = 1'b0;
            end
            // In-order retirement from the head
            if ((count != '0) && (ent_q[head].st == ST_DONE) && ent_q[head].npc_rdy) begin
                pop               = 1'b1;
                ent_d[head].st    = ST_FREE;
                ctl_d.cmt_valid   = 1'b1;
                ctl_d.cmt_has_dst = ent_q[head].has_dst;
                ctl_d.cmt_dst     = ent_q[head].dst;
                ctl_d.cmt_val     = ent_q[head].val;
                ctl_d.cmt_idx     = head;
                ctl_d.cmt_npc     = ent_q[head].res_npc;
                ctl_d.flush       = ent_q[head].mis;
                if (ent_q[head].instr == HALT_WORD) ctl_d.halt = {1'b1, a0_low};
                if (ent_q[head].instr[6:0] == OPC_JALR) begin
                    ctl_d.pred_valid = 1'b1;
                    ctl_d.pred_pc    = ent_q[head].res_npc;
                end
            end
            // Allocation at the tail
            if (iss_valid && iss_ready) begin
                push                 = 1'b1;
                ent_d[tail].st       = ST_WAIT;
                ent_d[tail].instr    = iss_instr;
                ent_d[tail].pred_npc = iss_pred_npc;
                ent_d[tail].res_npc  = iss_pc + 32'd4;
                ent_d[tail].has_dst  = iss_has_dst;
                ent_d[tail].dst      = iss_dst;
                ent_d[tail].val      = '0;
                ent_d[tail].mis      = 1'b0;
                ent_d[tail].npc_rdy  = (iss_instr[6:0] != OPC_JALR);
                ctl_d.issued_last    = 1'b1;
                ctl_d.last_idx       = tail;
                ctl_d.last_src[0]    = iss_src1;
                ctl_d.last_src[1]    = iss_src2;
                if (iss_instr[6:0] == OPC_JALR) ctl_d.pred_valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
        end else begin
            ctl_q <= ctl_d;
            ent_q <= ent_d;
        end
    end

    assign iss_idx     = tail;
    assign cmt_valid   = ctl_q.cmt_valid;
    assign cmt_has_dst = ctl_q.cmt_has_dst;
    assign cmt_dst     = ctl_q.cmt_dst;
    assign cmt_val     = ctl_q.cmt_val;
    assign cmt_idx     = ctl_q.cmt_idx;
    assign cmt_npc     = ctl_q.cmt_npc;
    assign flush       = ctl_q.flush;
    assign halt        = ctl_q.halt;
    assign pred_valid  = ctl_q.pred_valid;
    assign pred_pc     = ctl_q.pred_pc;
    assign op1_hit     = op_hit[0];
    assign op1_val     = op_val[0];
    assign op2_hit     = op_hit[1];
    assign op2_val     = op_val[1];
endmodule

// File: rtl/rob_commit_chk.sv
module rob_commit_chk #(
    parameter int DEPTH = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      iss_valid,
    input logic                      iss_ready,
    input logic [$clog2(DEPTH)-1:0]  iss_idx,
    input logic                      cmt_valid,
    input logic [$clog2(DEPTH)-1:0]  cmt_idx,
    input logic                      flush,
    input logic [8:0]                halt
);
    localparam int IW = $clog2(DEPTH);

    logic [IW-1:0] exp_idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         exp_idx_q <= '0;
        else if (flush)     exp_idx_q <= '0;
        else if (cmt_valid) exp_idx_q <= cmt_idx + 1'b1;
    end

    // R3
    alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> (iss_idx == IW'($past(iss_idx) + 1'b1)));

    // R5
    retire_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |-> (cmt_idx == exp_idx_q));

    // R7
    flush_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (cmt_valid && !iss_ready));

    // R7
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!cmt_valid && (iss_idx == '0)));

    // R8
    halt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt[8]) |-> cmt_valid);

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt[8] |=> $stable(halt));
endmodule

bind rob_commit_unit rob_commit_chk #(.DEPTH(DEPTH)) u_rob_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_idx   (iss_idx),
    .cmt_valid (cmt_valid),
    .cmt_idx   (cmt_idx),
    .flush     (flush),
    .halt      (halt)
);

// File: tb/test_rob_commit_unit.sv
`timescale 1ns/1ps
module test_rob_commit_unit;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [31:0] iss_instr = '0, iss_pc = '0, iss_pred_npc = '0;
    logic        iss_has_dst = 1'b0;
    logic [4:0]  iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [5:0]  q_free = 6'd8;
    logic        iss_ready;
    logic [4:0]  iss_idx;
    logic [1:0]  alu_stat = '0, mem_stat = '0;
    logic [4:0]  alu_idx = '0, mem_idx = '0;
    logic [31:0] alu_val = '0, alu_npc = '0, mem_val = '0;
    logic [7:0]  a0_low = '0;
    logic        cmt_valid, cmt_has_dst, flush, pred_valid, op1_hit, op2_hit;
    logic [4:0]  cmt_dst, cmt_idx;
    logic [31:0] cmt_val, cmt_npc, pred_pc, op1_val, op2_val;
    logic [8:0]  halt;

    int nvec = 0;
    int nbad = 0;

    always #4 clk = ~clk;

    rob_commit_unit #(.DEPTH(DEPTH)) i_rob_commit_unit (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_instr(iss_instr), .iss_pc(iss_pc),
        .iss_pred_npc(iss_pred_npc), .iss_has_dst(iss_has_dst), .iss_dst(iss_dst),
        .iss_src1(iss_src1), .iss_src2(iss_src2), .q_free(q_free),
        .iss_ready(iss_ready), .iss_idx(iss_idx),
        .alu_stat(alu_stat), .alu_idx(alu_idx), .alu_val(alu_val), .alu_npc(alu_npc),
        .mem_stat(mem_stat), .mem_idx(mem_idx), .mem_val(mem_val), .a0_low(a0_low),
        .cmt_valid(cmt_valid), .cmt_has_dst(cmt_has_dst), .cmt_dst(cmt_dst),
        .cmt_val(cmt_val), .cmt_idx(cmt_idx), .cmt_npc(cmt_npc), .flush(flush),
        .halt(halt), .pred_valid(pred_valid), .pred_pc(pred_pc),
        .op1_hit(op1_hit), .op1_val(op1_val), .op2_hit(op2_hit), .op2_val(op2_val)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] ins, input logic [31:0] pc, input logic [31:0] pnpc,
                         input bit hd, input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2,
                         output logic [4:0] idx);
        iss_valid = 1'b1; iss_instr = ins; iss_pc = pc; iss_pred_npc = pnpc;
        iss_has_dst = hd; iss_dst = d; iss_src1 = s1; iss_src2 = s2;
        #1;
        idx = iss_idx;
        @(posedge clk); #1;
        iss_valid = 1'b0; iss_has_dst = 1'b0; iss_src1 = '0; iss_src2 = '0;
        #1;
    endtask

    task automatic alu_done(input logic [4:0] idx, input logic [31:0] v, input logic [31:0] npc);
        alu_stat = 2'b10; alu_idx = idx; alu_val = v; alu_npc = npc;
        @(posedge clk); #1;
        alu_stat = 2'b00;
    endtask

    task automatic mem_done(input logic [4:0] idx, input logic [31:0] v);
        mem_stat = 2'b10; mem_idx = idx; mem_val = v;
        @(posedge clk); #1;
        mem_stat = 2'b00;
    endtask

    task automatic exp_commit(input string req, input bit hd, input logic [4:0] d, input logic [31:0] v,
                              input logic [4:0] idx, input logic [31:0] npc, input bit fl);
        bit seen = 1'b0;
        for (int i = 0; i < 12 && !seen; i++) begin
            @(negedge clk);
            if (cmt_valid) seen = 1'b1;
        end
        chk(seen, {req, " commit seen"}, 32'(seen), 32'd1);
        if (seen) begin
            chk(cmt_idx == idx, {req, " slot"}, 32'(cmt_idx), 32'(idx));
            chk(cmt_has_dst == hd && (!hd || cmt_dst == d), {req, " dst"}, 32'({cmt_has_dst, cmt_dst}), 32'({hd, d}));
            chk(cmt_val == v, {req, " value"}, cmt_val, v);
            chk(cmt_npc == npc, {req, " npc"}, cmt_npc, npc);
            chk(flush == fl, {req, " flush"}, 32'(flush), 32'(fl));
        end
    endtask

    task automatic no_commit(input int n, input string req);
        bit bad = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cmt_valid) bad = 1'b1;
        end
        chk(!bad, req, 32'(bad), 32'd0);
    endtask

    task automatic drain(input int n, input string req);
        int got = 0;
        for (int i = 0; i < n * 2 + 40 && got < n; i++) begin
            @(negedge clk);
            if (cmt_valid) got++;
        end
        chk(got == n, req, 32'(got), 32'(n));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(iss_ready == 1'b1, "R1 ready", 32'(iss_ready), 32'd1);
        chk(iss_idx == 5'd0, "R1 idx", 32'(iss_idx), 32'd0);
        chk(!cmt_valid && !flush, "R1 commit/flush", 32'({cmt_valid, flush}), 32'd0);
        chk(halt == 9'd0 && !pred_valid, "R1 halt/pred", 32'({pred_valid, halt}), 32'd0);
    endtask

    task automatic t_order();
        logic [4:0] ia, ib;
        issue(32'h0030_0193, 32'h100, 32'h104, 1'b1, 5'd3, 5'd0, 5'd0, ia);
        chk(ia == 5'd0, "R3 first slot", 32'(ia), 32'd0);
        issue(32'h0040_0213, 32'h104, 32'h108, 1'b1, 5'd4, 5'd0, 5'd0, ib);
        chk(ib == 5'd1, "R3 next slot", 32'(ib), 32'd1);
        // R4: a status other than 2'b10 is ignored
        alu_stat = 2'b01; alu_idx = ia; alu_val = 32'hDEAD; alu_npc = 32'h104;
        @(posedge clk); #1 alu_stat = 2'b00;
        no_commit(4, "R4 bad status ignored");
        alu_done(ib, 32'hBBBB, 32'h108);
        no_commit(3, "R5 younger waits for head");
        mem_done(ia, 32'hAAAA);
        exp_commit("R5 R6 first", 1'b1, 5'd3, 32'hAAAA, ia, 32'h104, 1'b0);
        exp_commit("R5 R6 second", 1'b1, 5'd4, 32'hBBBB, ib, 32'h108, 1'b0);
    endtask

    task automatic t_operands();
        logic [4:0] ih, ic, ie, id, i_f, ig;
        issue(32'h0000_0013, 32'h200, 32'h204, 1'b0, 5'd0, 5'd0, 5'd0, ih);
        issue(32'h0050_0293, 32'h204, 32'h208, 1'b1, 5'd5, 5'd0, 5'd0, ic);
        alu_done(ic, 32'h55, 32'h208);
        issue(32'h0060_0313, 32'h208, 32'h20C, 1'b1, 5'd6, 5'd0, 5'd0, ie);
        issue(32'h0062_8033, 32'h20C, 32'h210, 1'b0, 5'd0, 5'd5, 5'd6, id);
        chk(op1_hit && op1_val == 32'h55, "R10 finished writer forwarded", {31'd0, op1_hit} ^ op1_val, 32'h54);
        chk(!op2_hit, "R10 pending writer not forwarded", 32'(op2_hit), 32'd0);
        issue(32'h0070_0293, 32'h210, 32'h214, 1'b1, 5'd5, 5'd0, 5'd0, i_f);
        issue(32'h0002_8033, 32'h214, 32'h218, 1'b0, 5'd0, 5'd5, 5'd0, ig);
        chk(!op1_hit, "R10 younger pending writer hides older", 32'(op1_hit), 32'd0);
        chk(!op2_hit, "R10 x0 never forwarded", 32'(op2_hit), 32'd0);
        mem_done(ie, 32'h66);
        mem_done(id, 32'h0);
        mem_done(i_f, 32'h77);
        mem_done(ig, 32'h0);
        mem_done(ih, 32'h0);
        drain(6, "R5 operand group retires");
    endtask

    task automatic t_jalr();
        logic [4:0] j1, j2;
        issue(32'h0000_80E7, 32'h300, 32'h400, 1'b1, 5'd1, 5'd1, 5'd0, j1);
        alu_done(j1, 32'h304, 32'h400);
        exp_commit("R9 jalr retire", 1'b1, 5'd1, 32'h304, j1, 32'h400, 1'b0);
        chk(pred_valid && pred_pc == 32'h400, "R9 predicted pc set", pred_pc, 32'h400);
        issue(32'h0000_80E7, 32'h400, 32'h500, 1'b1, 5'd1, 5'd1, 5'd0, j2);
        chk(!pred_valid, "R9 issue withdraws prediction", 32'(pred_valid), 32'd0);
        alu_done(j2, 32'h404, 32'h500);
        exp_commit("R9 second jalr", 1'b1, 5'd1, 32'h404, j2, 32'h500, 1'b0);
        chk(pred_valid && pred_pc == 32'h500, "R9 predicted pc updated", pred_pc, 32'h500);
    endtask

    task automatic t_flush();
        logic [4:0] jx, kx;
        issue(32'h0000_0463, 32'h600, 32'h604, 1'b1, 5'd7, 5'd0, 5'd0, jx);
        issue(32'h0080_0413, 32'h604, 32'h608, 1'b1, 5'd8, 5'd0, 5'd0, kx);
        alu_done(jx, 32'h77, 32'h700);
        exp_commit("R7 mismatch", 1'b1, 5'd7, 32'h77, jx, 32'h700, 1'b1);
        chk(!iss_ready, "R7 no issue during flush", 32'(iss_ready), 32'd0);
        @(posedge clk); #1;
        chk(iss_idx == 5'd0 && iss_ready, "R7 emptied after flush", 32'(iss_idx), 32'd0);
        alu_done(kx, 32'h88, 32'h608);
        no_commit(5, "R7 flushed slot never retires");
    endtask

    task automatic t_space();
        logic [4:0] ix;
        q_free = 6'd1; #1;
        chk(iss_ready, "R2 ready with one queue slot", 32'(iss_ready), 32'd1);
        issue(32'h0000_0013, 32'h900, 32'h904, 1'b0, 5'd0, 5'd0, 5'd0, ix);
        chk(ix == 5'd0, "R3 slot after flush", 32'(ix), 32'd0);
        chk(!iss_ready, "R2 previous issue consumes queue slot", 32'(iss_ready), 32'd0);
        @(posedge clk); #1;
        chk(iss_ready, "R2 ready again", 32'(iss_ready), 32'd1);
        q_free = 6'd0; #1;
        chk(!iss_ready, "R2 queue full", 32'(iss_ready), 32'd0);
        q_free = 6'd8; #1;
        for (int i = 1; i < DEPTH; i++) begin
            issue(32'h0000_0013, 32'h904 + 32'(i * 4), 32'h908 + 32'(i * 4), 1'b0, 5'd0, 5'd0, 5'd0, ix);
        end
        chk(ix == 5'(DEPTH - 1), "R3 wraps to last slot", 32'(ix), 32'(DEPTH - 1));
        chk(!iss_ready, "R11 full buffer blocks issue", 32'(iss_ready), 32'd0);
        for (int i = 1; i < DEPTH; i++) mem_done(5'(i), 32'(i));
        mem_done(5'd0, 32'd0);
        drain(DEPTH, "R11 full buffer drains");
    endtask

    task automatic t_halt();
        logic [4:0] hx;
        a0_low = 8'h2A;
        issue(32'h0FF0_0513, 32'hA00, 32'hA04, 1'b1, 5'd10, 5'd0, 5'd0, hx);
        chk(halt == 9'd0, "R8 no halt before retire", 32'(halt), 32'd0);
        alu_done(hx, 32'hFF, 32'hA04);
        exp_commit("R8 exit retire", 1'b1, 5'd10, 32'hFF, hx, 32'hA04, 1'b0);
        chk(halt == 9'h12A, "R8 halt code", 32'(halt), 32'h12A);
    endtask

    initial begin
        #(8 * 150000);
        nbad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_operands();
        t_jalr();
        t_flush();
        t_space();
        t_halt();
        repeat (2) @(posedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule